// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It takes the single product-sum result for its pin and turns it into pin data, a pin enable and a feedback bit that goes back into the logic array. A two-bit static configuration decides three things: whether the pin is driven from a clocked register or straight from the product sum, whether the pin data is inverted, and where the feedback bit comes from.

The cell's register is shared with two device-wide terms. The clear term is asynchronous and has top priority. The set term is synchronous and loads a one at the next rising clock edge. A per-cell enable term gates the pin driver. When the register is in use, feedback is taken ahead of the pin driver, so it stays valid while the pin floats. When the register is bypassed, feedback is the level read back from the pin. One device instantiates this cell once per I/O pin and connects the shared terms to every copy.

Top module: `pld_out_macrocell`

## Requirements
- R1: `cfg[1]` selects the path: 0 means the pin is driven from the register, 1 means the pin is driven from `sop_term` with no register in the way. `cfg[0]` selects the polarity: 1 means active-high (the value is passed through) and 0 means active-low (the value is inverted).
- R2: When `ar_term` and `sp_term` are both low, the register loads `sop_term` on each rising edge of `clk`.
- R3: While `ar_term` is high, the register reads 0, with no clock edge needed. It keeps reading 0 at a clock edge even when `sp_term` is also high.
- R4: When `sp_term` is high and `ar_term` is low, the register becomes 1 at the next rising clock edge, whatever the value of `sop_term`.
- R5: In registered modes (`cfg[1]`=0), `pin_data` equals the register value when `cfg[0]`=1 and its inverse when `cfg[0]`=0.
- R6: In registered modes, `array_fb` equals `pin_data`, whatever the values of `oe_term` and `pin_in`.
- R7: In combinational modes (`cfg[1]`=1), `pin_data` follows `sop_term` (when `cfg[0]`=1) or its inverse (when `cfg[0]`=0) within the same cycle. Neither `sp_term` nor the register affects it.
- R8: In combinational modes, `array_fb` equals `pin_in`.
- R9: `pin_oe` equals `oe_term` in every mode. A low value means the pin is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; the register loads on its rising edge |
| ar_term | input | 1 | Shared asynchronous clear product term, active high |
| sp_term | input | 1 | Shared synchronous set product term, active high |
| sop_term | input | 1 | This cell's sum-of-products result |
| oe_term | input | 1 | This cell's output-enable product term |
| cfg | input | 2 | Static configuration: bit 1 selects the path, bit 0 selects the polarity |
| pin_in | input | 1 | Level read back from the pin |
| pin_data | output | 1 | Data presented to the pin driver |
| pin_oe | output | 1 | Pin driver enable; 0 means high-impedance |
| array_fb | output | 1 | Feedback bit returned to the logic array |

## Verification
The hardest case to reach is the registered-mode feedback while the pin floats and the read-back level disagrees with the register. Only there does taking the feedback from the wrong source show up. The stimulus loads a known value into the register, drops `oe_term`, and drives `pin_in` to the opposite level, then toggles `pin_in` between clock edges while watching `array_fb`. Clearing the register asynchronously between clock edges is the other case that needs a directed step, because a clocked clear would look the same at the edges.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int CFG_W = 2;

  typedef struct packed {
    logic registered;
    logic active_high;
  } mc_mode_t;

  function automatic mc_mode_t decode_cfg(input logic [CFG_W-1:0] c);
    mc_mode_t m;
    m.registered  = ~c[1];
    m.active_high = c[0];
    return m;
  endfunction

endpackage

// File: rtl/mc_mode_decode.sv
module mc_mode_decode
  import mc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output mc_mode_t         mode
);
  always_comb mode = decode_cfg(cfg);
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg #(
  parameter logic CLR_VAL = 1'b0,
  parameter logic SET_VAL = 1'b1
) (
  input  logic clk,
  input  logic ar_term,
  input  logic sp_term,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge ar_term) begin
    if (ar_term)      q <= CLR_VAL;
    else if (sp_term) q <= SET_VAL;
    else              q <= d;
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (ar_term)
    (!sp_term) |=> (q == $past(d)));

  // R3
  clear_chk: assert property (@(posedge clk)
    ar_term |-> (q == CLR_VAL));

  // R4
  preset_chk: assert property (@(posedge clk) disable iff (ar_term)
    sp_term |=> (q == SET_VAL));
endmodule

// File: rtl/mc_output_stage.sv
module mc_output_stage
  import mc_pkg::*;
(
  input  mc_mode_t mode,
  input  logic     q,
  input  logic     sop,
  input  logic     oe,
  input  logic     pin_in,
  output logic     pin_data,
  output logic     pin_oe,
  output logic     fb
);
  logic src;

  always_comb begin
    src      = mode.registered ? q : sop;
    pin_data = mode.active_high ? src : ~src;
    pin_oe   = oe;
    fb       = mode.registered ? pin_data : pin_in;
  end
endmodule

// File: rtl/pld_out_macrocell.sv
module pld_out_macrocell
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             ar_term,
  input  logic             sp_term,
  input  logic             sop_term,
  input  logic             oe_term,
  input  logic [CFG_W-1:0] cfg,
  input  logic             pin_in,
  output logic             pin_data,
  output logic             pin_oe,
  output logic             array_fb
);
  mc_mode_t mode;
  logic     q;

  mc_mode_decode u_dec (.cfg(cfg), .mode(mode));

  mc_state_reg #(.CLR_VAL(1'b0), .SET_VAL(1'b1)) u_reg (
    .clk(clk), .ar_term(ar_term), .sp_term(sp_term), .d(sop_term), .q(q)
  );

  mc_output_stage u_out (
    .mode(mode), .q(q), .sop(sop_term), .oe(oe_term), .pin_in(pin_in),
    .pin_data(pin_data), .pin_oe(pin_oe), .fb(array_fb)
  );

  // R6
  reg_fb_chk: assert property (@(posedge clk) disable iff (ar_term)
    (!cfg[1]) |-> (array_fb == pin_data));

  // R5
  reg_pol_chk: assert property (@(posedge clk) disable iff (ar_term)
    (!cfg[1]) |-> (pin_data == (cfg[0] ? q : ~q)));
endmodule

// File: tb/pld_out_macrocell_tb.sv
module pld_out_macrocell_tb;
  logic clk = 1'b0;
  logic ar_term = 1'b1, sp_term = 1'b0, sop_term = 1'b0, oe_term = 1'b0, pin_in = 1'b0;
  logic [1:0] cfg = 2'b01;
  logic pin_data, pin_oe, array_fb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pld_out_macrocell u_dut (
    .clk(clk), .ar_term(ar_term), .sp_term(sp_term), .sop_term(sop_term),
    .oe_term(oe_term), .cfg(cfg), .pin_in(pin_in),
    .pin_data(pin_data), .pin_oe(pin_oe), .array_fb(array_fb)
  );

  // {cfg, sop, oe, pin_in, sp, exp_data, exp_oe, exp_fb}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'b01_1_1_0_0_1_1_1,  // R2 R5 R6 load 1 active-high
    9'b01_0_1_1_0_0_1_0,  // R2 R6 load 0, pin disagrees
    9'b00_1_1_1_0_0_1_0,  // R5 active-low inverts
    9'b00_0_0_1_0_1_0_1,  // R6 R9 pin floats, fb from register
    9'b01_0_0_0_1_1_0_1,  // R4 preset beats sop
    9'b00_0_1_0_1_0_1_0,  // R4 preset, active-low
    9'b11_1_1_0_0_1_1_0,  // R7 R8 comb active-high
    9'b11_0_1_1_0_0_1_1,  // R7 R8
    9'b10_1_1_1_0_0_1_1,  // R7 comb active-low
    9'b10_0_0_0_0_1_0_0,  // R8 R9
    9'b11_1_0_1_1_1_0_1,  // R7 preset ignored at pin
    9'b01_1_1_1_0_1_1_1   // R1 back to registered
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200 chk("R3 reset state data", pin_data, 1'b0);
    chk("R3 reset state fb", array_fb, 1'b0);
    cfg = 2'b00; #1;
    chk("R3 reset state active-low", pin_data, 1'b1);
    @(negedge clk); ar_term = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cfg, sop_term, oe_term, pin_in, sp_term} = VEC[i][8:3];
      @(posedge clk); #2;
      chk("R1 vector data", pin_data, VEC[i][2]);
      chk("R9 vector oe", pin_oe, VEC[i][1]);
      chk("R6 vector fb", array_fb, VEC[i][0]);
    end

    // R3: asynchronous clear without a clock edge
    @(negedge clk); sp_term = 0; cfg = 2'b01; sop_term = 1; oe_term = 1;
    @(posedge clk); #2 chk("R2 setup load", pin_data, 1'b1);
    ar_term = 1'b1; #1;
    chk("R3 async clear", pin_data, 1'b0);
    // R3 priority over preset
    sp_term = 1'b1;
    @(posedge clk); #2 chk("R3 clear beats preset", pin_data, 1'b0);
    @(negedge clk); ar_term = 0; sp_term = 0;
    @(posedge clk); #2 chk("R2 load after clear", pin_data, 1'b1);

    // R6: registered fb ignores pin_in toggling mid-cycle
    @(negedge clk); oe_term = 0; pin_in = 0; #1;
    chk("R6 fb ignores pin low", array_fb, 1'b1);
    pin_in = 1; #1 chk("R6 fb ignores pin high", array_fb, 1'b1);
    chk("R9 pin floats", pin_oe, 1'b0);

    // R7/R8: combinational paths act within the cycle
    cfg = 2'b11; #1;
    sop_term = 0; #1 chk("R7 same-cycle data", pin_data, 1'b0);
    sop_term = 1; #1 chk("R7 same-cycle data rise", pin_data, 1'b1);
    cfg = 2'b10; #1 chk("R7 active-low comb", pin_data, 1'b0);
    pin_in = 0; #1 chk("R8 fb tracks pin low", array_fb, 1'b0);
    pin_in = 1; #1 chk("R8 fb tracks pin high", array_fb, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule